// File: doc/BRIEF.md
# Successive Approximation ADC Controller

This block runs a 10-bit successive approximation conversion. A one-clock start pulse clears the working code register. The block then tests one bit per step, from the most significant bit down. For each bit it first sets the bit in the code, and an external DAC turns that code into a trial voltage. An external comparator then reports whether the analog input is at or above the trial voltage. The bit is kept if it is, and cleared if it is not. The code register drives the DAC and is also the readable result.

A one-clock machine-cycle enable paces the whole sequence. A conversion takes exactly 62 machine cycles: 2 setup cycles, then 6 machine cycles for each of the 10 bits. Within each bit's group, the bit is set on the first machine cycle and the comparator is sampled on the sixth. When the conversion ends, busy falls and a sticky completion flag rises in the same clock. The flag also serves as the interrupt request. It stays set until a clear pulse or a new start. A start that arrives during a conversion abandons that conversion and begins again from the clear step.

Top module: `sar_adc_ctrl`

## Requirements
- R1: One clock after `start_i`, `code_o` is 0, `busy_o` is 1 and `done_irq_o` is 0, whatever the state before.
- R2: After a start, `code_o` stays 0 through the first 2 machine-cycle pulses (`mc_en_i` high at a clock edge). On the 3rd pulse, bit 9 is set (`code_o` = 10'h200).
- R3: `cmp_i` = 1 means the input is at or above the trial code. On a sampling pulse, the bit under test is kept when `cmp_i` = 1 and cleared when `cmp_i` = 0. For an integer input v, the final code is v clamped to 1023.
- R4: Bits are decided in the order 9 down to 0. Bit k is set on pulse 3+6*(9-k) and decided on pulse 8+6*(9-k). While busy, at most one bit of `code_o` changes per clock.
- R5: `busy_o` stays high through the first 61 machine-cycle pulses and falls at the edge of the 62nd. Clocks with `mc_en_i` low do not advance the conversion.
- R6: `done_irq_o` rises in the same clock in which `busy_o` falls.
- R7: `done_irq_o` stays set until a `clear_i` pulse or a `start_i` pulse clears it. `clear_i` leaves `code_o` unchanged.
- R8: A `start_i` during a conversion restarts it from the clear step. A full 62 pulses are then needed, counted from the new start.
- R9: While idle, `code_o` holds its value, and `mc_en_i` and `cmp_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mc_en_i | input | 1 | One-clock machine-cycle enable |
| start_i | input | 1 | One-clock conversion start pulse |
| clear_i | input | 1 | One-clock clear of the completion flag |
| cmp_i | input | 1 | Comparator: 1 when the input is at or above the trial code |
| code_o | output | 10 | Trial code to the DAC, and the conversion result |
| busy_o | output | 1 | High while a conversion runs |
| done_irq_o | output | 1 | Sticky completion flag and interrupt request |

## Verification
A wrong bit index or a wrong sampling step puts a wrong value on `code_o`. It shows within one machine cycle of the faulty edge, because that bus drives the DAC directly. An off-by-one in the setup or step counters moves the fall of `busy_o` and the rise of the flag away from the 62nd pulse. The bench therefore counts pulses exactly. It sweeps all 1024 input codes, which exposes any comparator decision bug in the final result. Gaps between enable pulses and restarts part-way through a conversion expose state that advances without an enable or that survives a restart.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
    typedef enum logic {
        PH_SETUP = 1'b0,
        PH_BITS  = 1'b1
    } sar_phase_e;
endpackage

// File: rtl/sar_adc_seq.sv
module sar_adc_seq
    import sar_adc_pkg::*;
#(
    parameter int NBITS      = 10,
    parameter int SETUP_MC   = 2,
    parameter int MC_PER_BIT = 6,
    localparam int IDX_W     = $clog2(NBITS),
    localparam int STEP_W    = $clog2(MC_PER_BIT),
    localparam int SET_W     = $clog2(SETUP_MC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             mc_en_i,
    output logic             busy_o,
    output logic             set_o,
    output logic             smp_o,
    output logic             done_o,
    output logic [IDX_W-1:0] idx_o
);
    typedef struct packed {
        logic                busy;
        sar_phase_e          phase;
        logic [SET_W-1:0]    setup_cnt;
        logic [STEP_W-1:0]   step;
        logic [IDX_W-1:0]    idx;
    } seq_t;

    seq_t st_d, st_q;
    logic set_d, smp_d, done_d;

    always_comb begin
        st_d   = st_q;
        set_d  = 1'b0;
        smp_d  = 1'b0;
        done_d = 1'b0;
        if (start_i) begin
            st_d.busy      = 1'b1;
            st_d.phase     = PH_SETUP;
            st_d.setup_cnt = '0;
            st_d.step      = '0;
            st_d.idx       = IDX_W'(NBITS - 1);
        end else if (st_q.busy && mc_en_i) begin
            unique case (st_q.phase)
                PH_SETUP: begin
                    if (st_q.setup_cnt == SET_W'(SETUP_MC - 1)) begin
                        st_d.phase = PH_BITS;
                        st_d.step  = '0;
                    end else begin
                        st_d.setup_cnt = st_q.setup_cnt + 1'b1;
                    end
                end
                PH_BITS: begin
                    if (st_q.step == '0) begin
                        set_d = 1'b1;
                    end
                    if (st_q.step == STEP_W'(MC_PER_BIT - 1)) begin
                        smp_d     = 1'b1;
                        st_d.step = '0;
                        if (st_q.idx == '0) begin
                            st_d.busy      = 1'b0;
                            st_d.phase     = PH_SETUP;
                            st_d.setup_cnt = '0;
                            done_d         = 1'b1;
                        end else begin
                            st_d.idx = st_q.idx - 1'b1;
                        end
                    end else begin
                        st_d.step = st_q.step + 1'b1;
                    end
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, phase: PH_SETUP, setup_cnt: '0, step: '0, idx: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o = st_q.busy;
    assign set_o  = set_d;
    assign smp_o  = smp_d;
    assign done_o = done_d;
    assign idx_o  = st_q.idx;
endmodule

// File: rtl/sar_adc_code.sv
module sar_adc_code #(
    parameter int NBITS   = 10,
    localparam int IDX_W  = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             set_i,
    input  logic             smp_i,
    input  logic             cmp_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [NBITS-1:0] code_o
);
    logic [NBITS-1:0] code_d, code_q;
    logic [NBITS-1:0] bit_mask;

    always_comb begin
        bit_mask = NBITS'(1) << idx_i;
        code_d   = code_q;
        if (clr_i) begin
            code_d = '0;
        end else begin
            if (set_i) begin
                code_d = code_d | bit_mask;
            end
            if (smp_i && !cmp_i) begin
                code_d = code_d & ~bit_mask;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else begin
            code_q <= code_d;
        end
    end

    assign code_o = code_q;
endmodule

// File: rtl/sar_adc_flag.sv
module sar_adc_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic done_i,
    input  logic start_i,
    input  logic clear_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (done_i) begin
            flag_d = 1'b1;
        end else if (start_i || clear_i) begin
            flag_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
    parameter int NBITS      = 10,
    parameter int SETUP_MC   = 2,
    parameter int MC_PER_BIT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mc_en_i,
    input  logic             start_i,
    input  logic             clear_i,
    input  logic             cmp_i,
    output logic [NBITS-1:0] code_o,
    output logic             busy_o,
    output logic             done_irq_o
);
    localparam int IDX_W = $clog2(NBITS);

    logic             set_stb;
    logic             smp_stb;
    logic             done_stb;
    logic [IDX_W-1:0] bit_idx;

    sar_adc_seq #(
        .NBITS      (NBITS),
        .SETUP_MC   (SETUP_MC),
        .MC_PER_BIT (MC_PER_BIT)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .mc_en_i (mc_en_i),
        .busy_o  (busy_o),
        .set_o   (set_stb),
        .smp_o   (smp_stb),
        .done_o  (done_stb),
        .idx_o   (bit_idx)
    );

    sar_adc_code #(
        .NBITS (NBITS)
    ) u_code (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (start_i),
        .set_i  (set_stb),
        .smp_i  (smp_stb),
        .cmp_i  (cmp_i),
        .idx_i  (bit_idx),
        .code_o (code_o)
    );

    sar_adc_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .done_i  (done_stb),
        .start_i (start_i),
        .clear_i (clear_i),
        .flag_o  (done_irq_o)
    );
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
    parameter int NBITS      = 10,
    parameter int SETUP_MC   = 2,
    parameter int MC_PER_BIT = 6,
    localparam int TOTAL     = SETUP_MC + NBITS * MC_PER_BIT,
    localparam int CNT_W     = $clog2(TOTAL + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mc_en_i,
    input logic             start_i,
    input logic             clear_i,
    input logic [NBITS-1:0] code_o,
    input logic             busy_o,
    input logic             done_irq_o
);
    logic [CNT_W-1:0] mc_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mc_cnt_q <= '0;
        end else if (start_i) begin
            mc_cnt_q <= '0;
        end else if (busy_o && mc_en_i) begin
            mc_cnt_q <= mc_cnt_q + 1'b1;
        end
    end

    p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (code_o == '0 && busy_o && !done_irq_o));

    p_one_bit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !start_i) |=> ($countones(code_o ^ $past(code_o)) <= 1));

    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (mc_cnt_q == CNT_W'(TOTAL)));

    p_busy_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (mc_cnt_q < CNT_W'(TOTAL)));

    p_flag_on_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_irq_o);

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_irq_o && !clear_i && !start_i) |=> done_irq_o);

    p_clear_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !busy_o && !start_i) |=> (!done_irq_o && $stable(code_o)));

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(code_o));
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(
    .NBITS      (NBITS),
    .SETUP_MC   (SETUP_MC),
    .MC_PER_BIT (MC_PER_BIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mc_en_i    (mc_en_i),
    .start_i    (start_i),
    .clear_i    (clear_i),
    .code_o     (code_o),
    .busy_o     (busy_o),
    .done_irq_o (done_irq_o)
);

// File: tb/sar_adc_ctrl_bench.sv
`timescale 1ns/1ps
module sar_adc_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mc_en = 1'b0;
    logic       start = 1'b0;
    logic       clear = 1'b0;
    logic       cmp;
    logic [9:0] code;
    logic       busy;
    logic       irq;
    int         vin = 0;
    int         checks = 0;
    int         failures = 0;

    always #10 clk = ~clk;

    assign cmp = (vin >= int'(code));

    sar_adc_ctrl u_sar_adc_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mc_en_i    (mc_en),
        .start_i    (start),
        .clear_i    (clear),
        .cmp_i      (cmp),
        .code_o     (code),
        .busy_o     (busy),
        .done_irq_o (irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic do_clear();
        @(negedge clk) clear = 1'b1;
        @(negedge clk) clear = 1'b0;
    endtask

    task automatic mc_run(input int n);
        @(negedge clk) mc_en = 1'b1;
        repeat (n) @(negedge clk);
        mc_en = 1'b0;
    endtask

    function automatic int clamp(input int v);
        return (v > 1023) ? 1023 : v;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("reset code", int'(code), 0);
        chk("reset busy", int'(busy), 0);
        chk("reset irq", int'(irq), 0);

        // R3 R5 R6: exhaustive sweep of input codes
        for (int v = 0; v < 1024; v++) begin
            vin = v;
            do_start();
            chk("R1 busy after start", int'(busy), 1);
            chk("R1 irq after start", int'(irq), 0);
            mc_run(61);
            chk("R5 busy after 61 pulses", int'(busy), 1);
            mc_run(1);
            chk("R5 busy after 62 pulses", int'(busy), 0);
            chk("R6 irq at completion", int'(irq), 1);
            chk("R3 result", int'(code), v);
        end

        // R3 over-range input clamps
        vin = 1500;
        do_start();
        mc_run(62);
        chk("R3 over-range", int'(code), clamp(vin));

        // R1 start clears flag and code
        chk("R1 irq before start", int'(irq), 1);
        vin = 16'h2AB;
        do_start();
        chk("R1 code cleared", int'(code), 0);
        chk("R1 irq cleared", int'(irq), 0);

        // R2 R4 trial sequence
        mc_run(2);
        chk("R2 code after setup", int'(code), 0);
        for (int i = 0; i < 10; i++) begin
            int b;
            int hi;
            b  = 9 - i;
            hi = vin & (1023 & ~((1 << (b + 1)) - 1));
            mc_run(1);
            chk($sformatf("R4 set bit %0d", b), int'(code), hi | (1 << b));
            if (i == 0) chk("R2 msb trial", int'(code), 16'h200);
            mc_run(5);
            chk($sformatf("R4 decide bit %0d", b), int'(code), vin & (1023 & ~((1 << b) - 1)));
        end
        chk("R6 irq after sequence", int'(irq), 1);
        chk("R5 busy after sequence", int'(busy), 0);

        // R9 idle: mc_en and comparator ignored, flag sticky (R7)
        vin = 5;
        mc_run(20);
        chk("R9 code held idle", int'(code), 16'h2AB);
        chk("R9 busy stays low", int'(busy), 0);
        chk("R7 irq sticky", int'(irq), 1);

        // R7 clear
        do_clear();
        chk("R7 irq cleared", int'(irq), 0);
        chk("R7 clear keeps code", int'(code), 16'h2AB);

        // R8 restart mid-conversion
        vin = 777;
        do_start();
        mc_run(30);
        vin = 300;
        do_start();
        chk("R8 restart code", int'(code), 0);
        chk("R8 restart busy", int'(busy), 1);
        mc_run(61);
        chk("R8 busy after 61", int'(busy), 1);
        chk("R8 irq after 61", int'(irq), 0);
        mc_run(1);
        chk("R8 done after 62", int'(busy), 0);
        chk("R8 result", int'(code), 300);

        // R5 sparse enable pulses
        vin = 613;
        do_start();
        for (int p = 1; p <= 62; p++) begin
            mc_run(1);
            if (p == 61) chk("R5 sparse busy at 61", int'(busy), 1);
            @(negedge clk);
            @(negedge clk);
            if (p == 61) chk("R5 gap no advance", int'(busy), 1);
        end
        chk("R5 sparse done", int'(busy), 0);
        chk("R6 sparse irq", int'(irq), 1);
        chk("R3 sparse result", int'(code), 613);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R5 watchdog act=timeout exp=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule